// File: doc/BRIEF.md
# Transfer Count and Status Tracker

This block follows the byte progress of one transfer through a data coding coprocessor. The coprocessor has two byte ports. In the compress directions, port A takes data in and port B sends data out. In the decompress directions, port B takes data in and port A sends data out. The block keeps a programmable transfer size, a data-skip threshold and one byte counter for each port. From these it produces the run state, the completion flag, the expansion flag, the skip-window flag, two error flags and an enable for the output port.

The surrounding engine reports each byte that moves on a port with a one-cycle strobe. It also raises an end-of-record strobe together with the final output byte, and pulses an end-marker strobe when it decodes the closing control code. A start command latches the operating mode and zeroes both counters. Pause and resume commands halt and continue the count. A byte-wide register port gives access to the size, the threshold, the error mask and both counters.

Top module: `xfer_tracker`

## Requirements
- R1: After reset, busy, done, expand, skip-window and both error flags are low, out_en_o is high, and the size, threshold, mask and both counters read as zero.
- R2: A start sets busy and latches mode_i (00 compress, 01 compress pass-through, 10 decompress, 11 decompress with output skip). In the same step it zeroes both counters and clears done, expand and both error flags. The size and the threshold keep their values.
- R3: While busy, each port counter advances by exactly one per strobe on its port. While not busy, strobes leave the counters unchanged.
- R4: Completion sets done and clears busy. In modes 00, 10 and 11 this happens on an output-port strobe that carries end-of-record. In mode 01 it happens on the port B strobe that brings the port B count equal to the size.
- R5: At completion in mode 00, expand is set if the port B count after the final byte is larger than the size. A 9/8 expansion sets expand and raises no overflow.
- R6: An output-side strobe when that counter already holds its maximum value raises the overflow error, and the count stays at its maximum. The output side is port B in modes 00/01 and port A in modes 10/11.
- R7: In mode 11, out_en_o is low while the port A count is below the threshold, and it is high once the count is equal or greater. The skip-window flag is high only in that low window while a transfer is active or paused.
- R8: In modes 10/11, the end-marker error is raised in two cases. The first is a marker that arrives while the port B count, including any same-cycle byte, is below the size. The second is a port B strobe that reaches the size with no marker seen in this transfer and none in that cycle.
- R9: The mask register holds bit 0 for overflow and bit 1 for end-marker, where 1 means masked. An unmasked error clears busy. A masked error still sets its flag, and busy stays high.
- R10: A pause while busy clears busy and freezes both counters. A resume while paused sets busy again, and counting continues from the held values.
- R11: Register address bits [4:2] select the register: 0 size, 1 threshold, 2 port A count, 3 port B count, 4 mask. Bits [1:0] select the byte, with byte 0 holding bits 7:0. Writes change the size, threshold and mask only while not busy. The counters are read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Operating mode, latched by start |
| start_i | input | 1 | Begin a new transfer |
| pause_i | input | 1 | Halt the running transfer |
| resume_i | input | 1 | Continue a paused transfer |
| a_byte_i | input | 1 | One byte moved on port A |
| b_byte_i | input | 1 | One byte moved on port B |
| eor_i | input | 1 | Current output byte is the last of the record |
| end_mark_i | input | 1 | End control code decoded |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register select and byte select |
| reg_wdata_i | input | 8 | Register write byte |
| reg_rdata_o | output | 8 | Register read byte, combinational |
| busy_o | output | 1 | Transfer running |
| done_o | output | 1 | Transfer completed |
| expand_o | output | 1 | Compressed output exceeded the size |
| outdis_o | output | 1 | Output bytes are being discarded |
| ovf_err_o | output | 1 | Output-side counter overflow |
| end_err_o | output | 1 | End-marker position mismatch |
| out_en_o | output | 1 | Output port may deliver bytes |

## Verification
A wrong count appears at the register port in the cycle after the strobe edge. It also shifts every later size comparison, so completion, expand or the end-marker error arrives a byte early or late. A wrong latched mode changes which port is treated as the output side. That shows up at once on out_en_o, and at the end of the transfer as an overflow or completion on the wrong port. A flag that fails to clear on start persists into the next transfer and is visible one cycle after the start.

// File: rtl/xfer_pkg.sv
// Shared definitions for the transfer tracker: mode encoding and register
// select codes. Assumes four byte lanes per register at most.
package xfer_pkg;
    typedef enum logic [1:0] {
        MODE_CMP      = 2'b00,
        MODE_CMP_PASS = 2'b01,
        MODE_DEC      = 2'b10,
        MODE_DEC_SKIP = 2'b11
    } xfer_mode_e;

    localparam int REG_ADDR_W = 5;

    typedef enum logic [2:0] {
        RG_SIZE = 3'd0,
        RG_SKIP = 3'd1,
        RG_ACNT = 3'd2,
        RG_BCNT = 3'd3,
        RG_MASK = 3'd4
    } reg_sel_e;
endpackage

// File: rtl/xfer_counter.sv
// Saturating byte counter with a synchronous clear.
// sat_hit flags an increment request while the count is already at maximum.
module xfer_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         sat_hit
);
    localparam logic [W-1:0] MAXV = '1;

    logic at_max;
    assign at_max  = (cnt == MAXV);
    assign sat_hit = inc && at_max;

    // Count strobes; clear wins; hold at maximum.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (clr)              cnt <= '0;
        else if (inc && !at_max)   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/xfer_regs.sv
// Byte-wide register file: size, skip threshold and error mask are writable
// while unlocked; both counters are read back through the same mux.
// Assumes W is a multiple of 8, at least 16 and at most 32.
module xfer_regs import xfer_pkg::*; #(
    parameter int W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_i,
    input  logic [REG_ADDR_W-1:0] addr_i,
    input  logic [7:0]            wdata_i,
    input  logic                  lock_i,
    input  logic [W-1:0]          a_cnt_i,
    input  logic [W-1:0]          b_cnt_i,
    output logic [W-1:0]          size_o,
    output logic [W-1:0]          skip_o,
    output logic [1:0]            mask_o,
    output logic [7:0]            rdata_o
);
    reg_sel_e     sel;
    logic [4:0]   sh;
    logic [W-1:0] lane_clr;
    logic [W-1:0] lane_set;
    logic [W-1:0] rsel;
    logic [W-1:0] rshift;

    assign sel      = reg_sel_e'(addr_i[4:2]);
    assign sh       = {addr_i[1:0], 3'b000};
    assign lane_clr = ~(W'(8'hFF) << sh);
    assign lane_set = W'(wdata_i) << sh;

    // Byte-lane writes, accepted only when the transfer is not running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_o <= '0;
            skip_o <= '0;
            mask_o <= '0;
        end else if (wr_i && !lock_i) begin
            case (sel)
                RG_SIZE: size_o <= (size_o & lane_clr) | lane_set;
                RG_SKIP: skip_o <= (skip_o & lane_clr) | lane_set;
                RG_MASK: if (addr_i[1:0] == 2'b00) mask_o <= wdata_i[1:0];
                default: ;
            endcase
        end
    end

    // Read mux: pick the register, then shift the addressed byte down.
    always_comb begin
        case (sel)
            RG_SIZE: rsel = size_o;
            RG_SKIP: rsel = skip_o;
            RG_ACNT: rsel = a_cnt_i;
            RG_BCNT: rsel = b_cnt_i;
            RG_MASK: rsel = W'(mask_o);
            default: rsel = '0;
        endcase
        rshift  = rsel >> sh;
        rdata_o = rshift[7:0];
    end
endmodule

// File: rtl/xfer_status.sv
// Transfer run state and status flags. Takes gated port strobes, the
// counter values and saturation hits; decides completion, expansion,
// overflow, end-marker mismatch, pause/resume and the output skip window.
// Assumes the counters are cleared by the same start pulse seen here.
module xfer_status import xfer_pkg::*; #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode_i,
    input  logic         start_i,
    input  logic         pause_i,
    input  logic         resume_i,
    input  logic [1:0]   stb_i,
    input  logic [1:0]   hit_i,
    input  logic         eor_i,
    input  logic         end_mark_i,
    input  logic [W-1:0] size_i,
    input  logic [W-1:0] skip_i,
    input  logic [1:0]   mask_i,
    input  logic [W-1:0] a_cnt_i,
    input  logic [W-1:0] b_cnt_i,
    output logic         busy_o,
    output logic         done_o,
    output logic         expand_o,
    output logic         ovf_err_o,
    output logic         end_err_o,
    output logic         outdis_o,
    output logic         out_en_o
);
    xfer_mode_e   mode_q;
    logic         paused_q;
    logic         mark_seen_q;
    logic         cmp_dir;
    logic         dec_dir;
    logic [W-1:0] b_after;
    logic         fin_cmp, fin_pass, fin_dec, finish;
    logic         ovf_hit, mark_early, mark_missing, end_hit, stop_err;
    logic         skip_low;

    assign cmp_dir = (mode_q == MODE_CMP) || (mode_q == MODE_CMP_PASS);
    assign dec_dir = !cmp_dir;
    assign b_after = hit_i[1] ? b_cnt_i : b_cnt_i + W'(stb_i[1]);

    // Completion and error detection for the current cycle.
    always_comb begin
        fin_cmp      = (mode_q == MODE_CMP) && stb_i[1] && eor_i;
        fin_pass     = (mode_q == MODE_CMP_PASS) && stb_i[1] && (b_after == size_i);
        fin_dec      = dec_dir && stb_i[0] && eor_i;
        finish       = fin_cmp || fin_pass || fin_dec;
        ovf_hit      = cmp_dir ? hit_i[1] : hit_i[0];
        mark_early   = busy_o && dec_dir && end_mark_i && (b_after < size_i);
        mark_missing = dec_dir && stb_i[1] && (b_after == size_i)
                       && !mark_seen_q && !end_mark_i;
        end_hit      = mark_early || mark_missing;
        stop_err     = (ovf_hit && !mask_i[0]) || (end_hit && !mask_i[1]);
    end

    // Run state and sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q      <= MODE_CMP;
            busy_o      <= 1'b0;
            paused_q    <= 1'b0;
            done_o      <= 1'b0;
            expand_o    <= 1'b0;
            ovf_err_o   <= 1'b0;
            end_err_o   <= 1'b0;
            mark_seen_q <= 1'b0;
        end else if (start_i) begin
            mode_q      <= xfer_mode_e'(mode_i);
            busy_o      <= 1'b1;
            paused_q    <= 1'b0;
            done_o      <= 1'b0;
            expand_o    <= 1'b0;
            ovf_err_o   <= 1'b0;
            end_err_o   <= 1'b0;
            mark_seen_q <= 1'b0;
        end else begin
            if (ovf_hit) ovf_err_o <= 1'b1;
            if (end_hit) end_err_o <= 1'b1;
            if (busy_o && end_mark_i) mark_seen_q <= 1'b1;
            if (finish) begin
                done_o <= 1'b1;
                busy_o <= 1'b0;
                if (mode_q == MODE_CMP) expand_o <= (b_after > size_i);
            end else if (stop_err) begin
                busy_o <= 1'b0;
            end else if (pause_i && busy_o) begin
                busy_o   <= 1'b0;
                paused_q <= 1'b1;
            end else if (resume_i && paused_q) begin
                busy_o   <= 1'b1;
                paused_q <= 1'b0;
            end
        end
    end

    // Output skip window for the discard-until-threshold mode.
    assign skip_low = (mode_q == MODE_DEC_SKIP) && (a_cnt_i < skip_i);
    assign out_en_o = !skip_low;
    assign outdis_o = skip_low && (busy_o || paused_q);
endmodule

// File: rtl/xfer_tracker.sv
// Top of the transfer tracker: two port counters (generated), the register
// file and the status logic. Strobes count only while busy.
module xfer_tracker import xfer_pkg::*; #(
    parameter int CNT_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            mode_i,
    input  logic                  start_i,
    input  logic                  pause_i,
    input  logic                  resume_i,
    input  logic                  a_byte_i,
    input  logic                  b_byte_i,
    input  logic                  eor_i,
    input  logic                  end_mark_i,
    input  logic                  reg_wr_i,
    input  logic [REG_ADDR_W-1:0] reg_addr_i,
    input  logic [7:0]            reg_wdata_i,
    output logic [7:0]            reg_rdata_o,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  expand_o,
    output logic                  outdis_o,
    output logic                  ovf_err_o,
    output logic                  end_err_o,
    output logic                  out_en_o
);
    localparam int NPORT = 2;

    logic [NPORT-1:0] stb;
    logic [NPORT-1:0] hit;
    logic [CNT_W-1:0] cnt [NPORT];
    logic [CNT_W-1:0] a_cnt;
    logic [CNT_W-1:0] b_cnt;
    logic [CNT_W-1:0] size_r;
    logic [CNT_W-1:0] skip_r;
    logic [1:0]       mask_r;

    assign stb   = {b_byte_i, a_byte_i} & {NPORT{busy_o}};
    assign a_cnt = cnt[0];
    assign b_cnt = cnt[1];

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        xfer_counter #(.W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (start_i),
            .inc     (stb[p]),
            .cnt     (cnt[p]),
            .sat_hit (hit[p])
        );
    end

    xfer_regs #(.W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .lock_i  (busy_o),
        .a_cnt_i (a_cnt),
        .b_cnt_i (b_cnt),
        .size_o  (size_r),
        .skip_o  (skip_r),
        .mask_o  (mask_r),
        .rdata_o (reg_rdata_o)
    );

    xfer_status #(.W(CNT_W)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_i),
        .start_i    (start_i),
        .pause_i    (pause_i),
        .resume_i   (resume_i),
        .stb_i      (stb),
        .hit_i      (hit),
        .eor_i      (eor_i),
        .end_mark_i (end_mark_i),
        .size_i     (size_r),
        .skip_i     (skip_r),
        .mask_i     (mask_r),
        .a_cnt_i    (a_cnt),
        .b_cnt_i    (b_cnt),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .expand_o   (expand_o),
        .ovf_err_o  (ovf_err_o),
        .end_err_o  (end_err_o),
        .outdis_o   (outdis_o),
        .out_en_o   (out_en_o)
    );
endmodule

// File: rtl/xfer_tracker_chk.sv
// Property checker for the transfer tracker, bound to every instance.
module xfer_tracker_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         pause_i,
    input logic         busy_o,
    input logic         done_o,
    input logic         outdis_o,
    input logic         out_en_o,
    input logic         ovf_err_o,
    input logic [W-1:0] a_cnt
);
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(a_cnt)); // R3
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R4
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_err_o && !start_i) |=> ovf_err_o); // R6
    AST_SKIP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        outdis_o |-> !out_en_o); // R7
    AST_PAUSE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_i && busy_o && !start_i) |=> !busy_o); // R10
endmodule

bind xfer_tracker xfer_tracker_chk #(.W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .pause_i   (pause_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .outdis_o  (outdis_o),
    .out_en_o  (out_en_o),
    .ovf_err_o (ovf_err_o),
    .a_cnt     (a_cnt)
);

// File: tb/xfer_tracker_test.sv
`timescale 1ns/1ps
module xfer_tracker_test;
    localparam int W = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic       start_i = 0, pause_i = 0, resume_i = 0;
    logic       a_byte_i = 0, b_byte_i = 0, eor_i = 0, end_mark_i = 0;
    logic       reg_wr_i = 0;
    logic [4:0] reg_addr_i = '0;
    logic [7:0] reg_wdata_i = '0;
    logic [7:0] reg_rdata_o;
    logic busy_o, done_o, expand_o, outdis_o, ovf_err_o, end_err_o, out_en_o;

    int nchk = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    xfer_tracker #(.CNT_W(W)) uut (.*);

    typedef struct packed {
        logic [1:0]  mode;
        logic [15:0] size;
        logic [15:0] nin;
        logic [15:0] nout;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{2'b00, 16'd64, 16'd64, 16'd32},
        '{2'b00, 16'd64, 16'd64, 16'd72},
        '{2'b00, 16'd64, 16'd64, 16'd64},
        '{2'b01, 16'd10, 16'd10, 16'd10},
        '{2'b00, 16'd20, 16'd20, 16'd21}
    };

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = d;
        cyc();
        reg_wr_i = 0;
    endtask

    task automatic wr16(input logic [2:0] rg, input logic [15:0] v);
        wr({rg, 2'b00}, v[7:0]);
        wr({rg, 2'b01}, v[15:8]);
    endtask

    task automatic rd16(input logic [2:0] rg, output logic [15:0] v);
        reg_addr_i = {rg, 2'b00}; #1 v[7:0] = reg_rdata_o;
        reg_addr_i = {rg, 2'b01}; #1 v[15:8] = reg_rdata_o;
    endtask

    task automatic go(input logic [1:0] m);
        mode_i = m; start_i = 1;
        cyc();
        start_i = 0;
    endtask

    task automatic apulse(input int n);
        for (int i = 0; i < n; i++) begin a_byte_i = 1; cyc(); end
        a_byte_i = 0;
    endtask

    task automatic bpulse(input int n);
        for (int i = 0; i < n; i++) begin b_byte_i = 1; cyc(); end
        b_byte_i = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        // R1 reset state
        chk("R1 busy", busy_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 flags", {expand_o, outdis_o, ovf_err_o, end_err_o}, 0);
        chk("R1 out_en", out_en_o, 1);
        rd16(3'd0, v); chk("R1 size", v, 0);
        rd16(3'd3, v); chk("R1 bcnt", v, 0);

        // Table of compress / pass-through transfers: R3 R4 R5
        for (int k = 0; k < 5; k++) begin
            wr16(3'd0, VECS[k].size);
            go(VECS[k].mode);
            apulse(int'(VECS[k].nin));
            for (int i = 0; i < int'(VECS[k].nout); i++) begin
                b_byte_i = 1;
                eor_i = (i == int'(VECS[k].nout) - 1) && (VECS[k].mode == 2'b00);
                cyc();
            end
            b_byte_i = 0; eor_i = 0;
            chk("R4 done", done_o, 1);
            chk("R4 busy", busy_o, 0);
            chk("R5 expand", expand_o,
                (VECS[k].mode == 2'b00) && (VECS[k].nout > VECS[k].size));
            chk("R5 no ovf", ovf_err_o, 0);
            rd16(3'd2, v); chk("R3 acnt", v, VECS[k].nin);
            rd16(3'd3, v); chk("R3 bcnt", v, VECS[k].nout);
        end

        // R3 strobes ignored while idle
        apulse(3);
        rd16(3'd2, v); chk("R3 idle acnt", v, 20);

        // R2 restart zeroes counters, keeps size
        go(2'b00);
        rd16(3'd2, v); chk("R2 acnt clr", v, 0);
        rd16(3'd3, v); chk("R2 bcnt clr", v, 0);
        chk("R2 flags clr", {done_o, expand_o}, 0);
        rd16(3'd0, v); chk("R2 size kept", v, 20);

        // R11 write while busy ignored
        wr(5'b000_00, 8'h55);
        rd16(3'd0, v); chk("R11 locked", v, 20);

        // R10 pause and resume
        apulse(2);
        pause_i = 1; cyc(); pause_i = 0;
        chk("R10 paused busy", busy_o, 0);
        apulse(3);
        rd16(3'd2, v); chk("R10 held", v, 2);
        resume_i = 1; cyc(); resume_i = 0;
        chk("R10 resumed", busy_o, 1);
        apulse(1);
        rd16(3'd2, v); chk("R10 continue", v, 3);

        // R7 output skip window (paused transfer is replaced by start)
        pause_i = 1; cyc(); pause_i = 0;
        wr16(3'd1, 16'd5);
        wr16(3'd0, 16'd100);
        go(2'b11);
        chk("R7 outdis", outdis_o, 1);
        chk("R7 out_en low", out_en_o, 0);
        apulse(4);
        chk("R7 still low", out_en_o, 0);
        apulse(1);
        chk("R7 out_en high", out_en_o, 1);
        chk("R7 outdis clr", outdis_o, 0);
        rd16(3'd1, v); chk("R2 skip kept", v, 5);

        // R8 early marker, unmasked -> R9 stop
        pause_i = 1; cyc(); pause_i = 0;
        wr16(3'd1, 16'd0);
        wr16(3'd0, 16'd8);
        go(2'b10);
        bpulse(3);
        end_mark_i = 1; cyc(); end_mark_i = 0;
        chk("R8 early", end_err_o, 1);
        chk("R9 stop", busy_o, 0);

        // R8 size reached without marker
        wr16(3'd0, 16'd4);
        go(2'b10);
        chk("R2 err clr", end_err_o, 0);
        bpulse(4);
        chk("R8 missing", end_err_o, 1);

        // R9 masked error keeps running
        wr(5'b100_00, 8'h02);
        wr16(3'd0, 16'd8);
        go(2'b10);
        bpulse(3);
        end_mark_i = 1; cyc(); end_mark_i = 0;
        chk("R9 masked flag", end_err_o, 1);
        chk("R9 masked busy", busy_o, 1);

        // R4 clean decompress: marker with last input byte, eor on port A
        pause_i = 1; cyc(); pause_i = 0;
        wr(5'b100_00, 8'h00);
        wr16(3'd0, 16'd4);
        go(2'b10);
        bpulse(3);
        b_byte_i = 1; end_mark_i = 1; cyc(); b_byte_i = 0; end_mark_i = 0;
        apulse(5);
        a_byte_i = 1; eor_i = 1; cyc(); a_byte_i = 0; eor_i = 0;
        chk("R4 dec done", done_o, 1);
        chk("R8 no err", end_err_o, 0);
        rd16(3'd2, v); chk("R4 dec acnt", v, 6);

        // R6 output-side overflow in compress mode
        go(2'b00);
        bpulse(65536);
        chk("R6 ovf", ovf_err_o, 1);
        chk("R6 busy", busy_o, 0);
        rd16(3'd3, v); chk("R6 sat", v, 16'hFFFF);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule